// File: doc/BRIEF.md
# Per-Source-Node Request Acceptance Filter

This block screens every received asynchronous request header against two per-node enable maps. Each map holds one bit for each of the 64 node numbers on the local bus. The first map decides whether a requesting node may be served at all. The second map decides whether a request that was marked for the physical path may actually take that path. A request whose source bit is clear in the first map is left unacknowledged and is not queued anywhere. A request that passes is acknowledged. It goes to the physical path only when it asked for that path and the second map also enables its source. Every other accepted request goes to the general request queue.

Software programs each map in 32-bit halves through paired set and clear addresses. A write to a set address ORs ones into the selected half. A write to a clear address removes the bits that are one in the written data. A read from either address of a pair returns the half as it stands. Both maps come out of reset empty, so no node is served until software enables it.

A header is presented for one cycle with a valid strobe. The block registers it, and the verdict appears on the following cycle alongside a verdict-valid flag.

Top module: `node_req_filter`

## Requirements
- R1: After reset every map half reads as zero, `dec_valid` is low, and a request from any node is rejected (accept, to_physical and to_general all low).
- R2: A write with `cfg_addr[0]`=0 (set) ORs `cfg_wdata` into the half chosen by `cfg_addr[1]` (0 = nodes 0–31, 1 = nodes 32–63) of the map chosen by `cfg_addr[2]` (0 = general map, 1 = physical map). The other three halves are left unchanged.
- R3: A write with `cfg_addr[0]`=1 (clear) clears, in the addressed half, every bit where `cfg_wdata` is one, and leaves all other bits unchanged.
- R4: `cfg_rdata` returns the half chosen by `cfg_addr[2:1]`, whichever value `cfg_addr[0]` has.
- R5: Only bits 5:0 of `hdr_src_id` (the node number) select the map bit. Node n uses bit n of the low half for n < 32 and bit n−32 of the high half otherwise. Bits 15:6 (the bus number) have no effect.
- R6: If the source node's bit in the general map is clear, accept, to_physical and to_general are all low, whatever the physical map holds.
- R7: A request with `hdr_phys`=0 whose general-map bit is set gives accept=1, to_general=1, to_physical=0.
- R8: A request with `hdr_phys`=1 whose bits are set in both maps gives accept=1, to_physical=1, to_general=0.
- R9: A request with `hdr_phys`=1 whose general-map bit is set but whose physical-map bit is clear is redirected: accept=1, to_general=1, to_physical=0.
- R10: `dec_valid` is high exactly in the cycle after a cycle with `hdr_valid` high. All three verdict outputs are low whenever `dec_valid` is low. The verdict uses the map contents of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Map write strobe |
| cfg_addr | input | 3 | Bit 0 = clear/set op, bit 1 = half, bit 2 = map select |
| cfg_wdata | input | 32 | Write data (bit mask) |
| cfg_rdata | output | 32 | Contents of the addressed half |
| hdr_valid | input | 1 | Header strobe, one cycle per request |
| hdr_src_id | input | 16 | Source ID: bus number [15:6], node number [5:0] |
| hdr_phys | input | 1 | Request is bound for the physical path |
| dec_valid | output | 1 | Verdict valid, one cycle after the header |
| accept | output | 1 | Request is acknowledged |
| to_physical | output | 1 | Serve on the physical path |
| to_general | output | 1 | Queue to the general request context |

## Verification
The assertions check three things on every cycle. The verdict follows the header strobe by exactly one cycle. The two destinations never fire together, and an accepted request always picks exactly one of them. Neither acceptance nor physical routing ever happens without the matching map bit and, for routing, a physical-bound header. The bench scenarios cover what a per-cycle check cannot show. They confirm that set and clear writes reach only the addressed half, that both addresses of a pair read the same contents, and that the bus-number bits are ignored. They also confirm that the redirect and drop cases give the expected verdict for nodes at both edges of each half.

// File: rtl/nrf_pkg.sv
package nrf_pkg;

    // Field positions inside the map address
    localparam int OP_BIT = 0;  // 0 = set, 1 = clear

    typedef struct packed {
        logic accept;
        logic to_phys;
        logic to_gen;
    } verdict_t;

endpackage

// File: rtl/nrf_map.sv
module nrf_map #(
    parameter int NODE_W = 6,
    parameter int HALF_W = 32,
    localparam int NODES  = 1 << NODE_W,
    localparam int HALVES = NODES / HALF_W,
    localparam int HSEL_W = (HALVES > 1) ? $clog2(HALVES) : 1,
    localparam int BIT_W  = $clog2(HALF_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_clr,
    input  logic [HSEL_W-1:0] half_sel,
    input  logic [HALF_W-1:0] wr_data,
    output logic [HALF_W-1:0] rd_data,
    input  logic [NODE_W-1:0] node,
    output logic              hit
);

    logic [HALF_W-1:0] half_d [HALVES];
    logic [HALF_W-1:0] half_q [HALVES];

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        always_comb begin
            half_d[h] = half_q[h];
            if (wr_en && (half_sel == HSEL_W'(h))) begin
                if (wr_clr) half_d[h] = half_q[h] & ~wr_data;
                else        half_d[h] = half_q[h] |  wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) half_q[h] <= '0;
            else        half_q[h] <= half_d[h];
        end
    end

    logic [HSEL_W-1:0] node_half;
    logic [BIT_W-1:0]  node_bit;

    always_comb begin
        node_half = HSEL_W'(node >> BIT_W);
        node_bit  = node[BIT_W-1:0];
        rd_data   = half_q[half_sel];
        hit       = half_q[node_half][node_bit];
    end

endmodule

// File: rtl/nrf_decide.sv
module nrf_decide
    import nrf_pkg::*;
(
    input  logic     valid,
    input  logic     phys_req,
    input  logic     gen_hit,
    input  logic     phys_hit,
    output verdict_t verdict
);

    always_comb begin
        verdict.accept  = valid & gen_hit;
        verdict.to_phys = valid & gen_hit & phys_req & phys_hit;
        verdict.to_gen  = valid & gen_hit & ~(phys_req & phys_hit);
    end

endmodule

// File: rtl/node_req_filter.sv
module node_req_filter
    import nrf_pkg::*;
#(
    parameter int NODE_W = 6,
    parameter int HALF_W = 32,
    parameter int ID_W   = 16,
    localparam int NODES  = 1 << NODE_W,
    localparam int HALVES = NODES / HALF_W,
    localparam int HSEL_W = (HALVES > 1) ? $clog2(HALVES) : 1,
    localparam int ADDR_W = HSEL_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [HALF_W-1:0] cfg_wdata,
    output logic [HALF_W-1:0] cfg_rdata,
    input  logic              hdr_valid,
    input  logic [ID_W-1:0]   hdr_src_id,
    input  logic              hdr_phys,
    output logic              dec_valid,
    output logic              accept,
    output logic              to_physical,
    output logic              to_general
);

    typedef struct packed {
        logic              valid;
        logic              phys;
        logic [NODE_W-1:0] node;
    } hdr_t;

    hdr_t hdr_d, hdr_q;

    // Bus number is not part of the decision
    logic unused_bus_bits;
    assign unused_bus_bits = ^hdr_src_id[ID_W-1:NODE_W];

    always_comb begin
        hdr_d.valid = hdr_valid;
        hdr_d.phys  = hdr_phys;
        hdr_d.node  = hdr_src_id[NODE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hdr_q <= '0;
        else        hdr_q <= hdr_d;
    end

    // Address decode
    logic              op_clr;
    logic [HSEL_W-1:0] half_sel;
    logic              map_phys;

    always_comb begin
        op_clr   = cfg_addr[OP_BIT];
        half_sel = cfg_addr[HSEL_W:1];
        map_phys = cfg_addr[ADDR_W-1];
    end

    logic [HALF_W-1:0] gen_rd, phys_rd;
    logic              gen_hit, phys_hit;

    nrf_map #(.NODE_W(NODE_W), .HALF_W(HALF_W)) u_gen_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr & ~map_phys),
        .wr_clr   (op_clr),
        .half_sel (half_sel),
        .wr_data  (cfg_wdata),
        .rd_data  (gen_rd),
        .node     (hdr_q.node),
        .hit      (gen_hit)
    );

    nrf_map #(.NODE_W(NODE_W), .HALF_W(HALF_W)) u_phys_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr & map_phys),
        .wr_clr   (op_clr),
        .half_sel (half_sel),
        .wr_data  (cfg_wdata),
        .rd_data  (phys_rd),
        .node     (hdr_q.node),
        .hit      (phys_hit)
    );

    assign cfg_rdata = map_phys ? phys_rd : gen_rd;

    verdict_t verdict;

    nrf_decide u_decide (
        .valid    (hdr_q.valid),
        .phys_req (hdr_q.phys),
        .gen_hit  (gen_hit),
        .phys_hit (phys_hit),
        .verdict  (verdict)
    );

    always_comb begin
        dec_valid   = hdr_q.valid;
        accept      = verdict.accept;
        to_physical = verdict.to_phys;
        to_general  = verdict.to_gen;
    end

endmodule

// File: rtl/nrf_chk.sv
module nrf_chk (
    input logic clk,
    input logic rst_n,
    input logic hdr_valid,
    input logic hdr_phys_q,
    input logic gen_hit,
    input logic phys_hit,
    input logic dec_valid,
    input logic accept,
    input logic to_physical,
    input logic to_general
);

    // R10
    verdict_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> dec_valid);

    // R10
    no_spurious_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !dec_valid);

    // R10
    quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !(accept || to_physical || to_general));

    // R8
    one_destination_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({to_physical, to_general}));

    // R7
    accepted_routed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $countones({to_physical, to_general}) == 1);

    // R6
    accept_needs_gen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> gen_hit);

    // R9
    phys_needs_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_physical |-> (phys_hit && hdr_phys_q && accept));

endmodule

bind node_req_filter nrf_chk u_nrf_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_valid   (hdr_valid),
    .hdr_phys_q  (hdr_q.phys),
    .gen_hit     (gen_hit),
    .phys_hit    (phys_hit),
    .dec_valid   (dec_valid),
    .accept      (accept),
    .to_physical (to_physical),
    .to_general  (to_general)
);

// File: tb/tb_node_req_filter.sv
module tb_node_req_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        hdr_valid = 1'b0;
    logic [15:0] hdr_src_id = '0;
    logic        hdr_phys = 1'b0;
    logic        dec_valid, accept, to_physical, to_general;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;  // 50 MHz

    node_req_filter dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hdr_valid(hdr_valid),
        .hdr_src_id(hdr_src_id), .hdr_phys(hdr_phys), .dec_valid(dec_valid),
        .accept(accept), .to_physical(to_physical), .to_general(to_general)
    );

    // Addresses: bit0 clear, bit1 high half, bit2 physical map
    localparam logic [2:0] G_LO = 3'd0, G_HI = 3'd2, P_LO = 3'd4, P_HI = 3'd6;

    // {src_id[15:0], phys, exp accept, exp to_physical, exp to_general}
    localparam int NV = 12;
    localparam logic [19:0] VEC [NV] = '{
        {16'h0004, 1'b1, 3'b110},  // R8 node 4 physical
        {16'h0004, 1'b0, 3'b101},  // R7 node 4 general
        {16'h0006, 1'b1, 3'b101},  // R9 redirect
        {16'h0008, 1'b1, 3'b000},  // R6 phys bit only
        {16'h0000, 1'b0, 3'b000},  // R6 node 0
        {16'h0020, 1'b1, 3'b110},  // R8 node 32
        {16'h0021, 1'b1, 3'b101},  // R9 node 33
        {16'h003F, 1'b0, 3'b101},  // R7 node 63
        {16'h003E, 1'b0, 3'b000},  // R6 node 62
        {16'hFFC4, 1'b1, 3'b110},  // R5 bus 0x3FF node 4
        {16'h5560, 1'b0, 3'b101},  // R5 bus 0x155 node 32
        {16'h001F, 1'b1, 3'b000}   // R5 node 31 low-half edge
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [2:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp);
    endtask

    // Sends one header, returns {dec_valid, accept, to_physical, to_general}
    task automatic send(input logic [15:0] id, input logic ph, output logic [3:0] res);
        @(negedge clk);
        hdr_valid = 1'b1; hdr_src_id = id; hdr_phys = ph;
        @(negedge clk);
        hdr_valid = 1'b0;
        res = {dec_valid, accept, to_physical, to_general};
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        logic [3:0] r;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 dec_valid", {31'd0, dec_valid}, 32'd0);
        rst_n = 1'b1;
        rd_check("R1 gen lo", G_LO, 32'h0);
        rd_check("R1 gen hi", G_HI, 32'h0);
        rd_check("R1 phys lo", P_LO, 32'h0);
        rd_check("R1 phys hi", P_HI, 32'h0);
        send(16'h0004, 1'b1, r);
        check("R1 reject after reset", {28'd0, r}, {28'd0, 4'b1000});

        // R2 set accumulates, other halves untouched
        wr(G_LO, 32'h0000_00C0);
        wr(G_LO, 32'h0000_003F);
        rd_check("R2 gen lo OR", G_LO, 32'h0000_00FF);
        rd_check("R2 gen hi untouched", G_HI, 32'h0);
        rd_check("R2 phys lo untouched", P_LO, 32'h0);
        // R3 clear, R4 read at clear address
        wr(G_LO | 3'd1, 32'h0000_000F);
        rd_check("R3 gen lo cleared", G_LO, 32'h0000_00F0);
        rd_check("R4 read via clear addr", G_LO | 3'd1, 32'h0000_00F0);
        wr(G_HI, 32'h8000_0003);
        wr(P_LO, 32'h0000_0130);
        wr(P_HI, 32'h0000_0001);
        rd_check("R4 phys hi via clear addr", P_HI | 3'd1, 32'h0000_0001);
        rd_check("R2 phys lo", P_LO, 32'h0000_0130);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            send(VEC[i][19:4], VEC[i][3], r);
            check($sformatf("R5-R9 vector %0d", i), {28'd0, r}, {28'd0, 1'b1, VEC[i][2:0]});
        end

        // R10 verdict lasts one cycle
        @(negedge clk);
        check("R10 idle after verdict", {28'd0, dec_valid, accept, to_physical, to_general}, 32'd0);

        // R6 clearing the general bit drops even with physical bit set
        wr(G_LO | 3'd1, 32'h0000_0010);
        send(16'h0004, 1'b1, r);
        check("R6 node 4 after clear", {28'd0, r}, {28'd0, 4'b1000});
        // R9 clearing physical bit redirects node 5
        wr(P_LO | 3'd1, 32'h0000_0020);
        send(16'h0005, 1'b1, r);
        check("R9 node 5 redirect", {28'd0, r}, {28'd0, 4'b1101});

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule